// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display from a set of programmable registers. A pixel counter runs once per clock and a line counter steps at the end of each line. Window comparators on the two counts give the active-video, blank, CRT hsync and CRT vsync outputs. A second pair of syncs for a flat panel has its own timing registers.

Software reaches the registers over a plain 32-bit word bus. The write strobe, address and data are taken in one cycle, and the read data follows the read address combinationally. There is no back-pressure: no stream data passes through the block, so every pin is a plain control or status pin. Writes to any register other than the key register take effect only while the key register holds the unlock value. Every timing register packs two count-minus-one values. The timing registers are copied into shadow registers at the start of vertical blank, so a reprogrammed mode never tears a frame in mid-scan.

Top module: `rtg_raster`

## Requirements
- R1: After reset every register reads zero, both counters are zero and every sync, blank and active output is low.
- R2: Word address 0 is the key register and can always be written. A write to any other address changes nothing unless the key register holds 32'h00004758. Writing zero to the key register relocks the block. Reads are always permitted.
- R3: The word addresses are: 1 configuration, 2 H active/total, 3 H blank start/end, 4 H sync start/end, 5 V active/total, 6 V blank start/end, 7 V sync start/end, 8 panel H sync start/end, 9 panel V sync start/end. In each timing register the first value sits in bits 15:0 and the second in bits 31:16. Addresses 10 to 15 read zero and ignore writes.
- R4: Configuration bit 0 enables the generator, bit 1 enables blank, bit 2 enables hsync, bit 3 enables vsync and bit 4 enables both panel syncs. An output whose enable bit is clear stays low.
- R5: The pixel count runs from 0 up to the H total field and then returns to 0. The line count steps when the pixel count wraps, and returns to 0 after it reaches the V total field.
- R6: The active output is high while the pixel count is at most the H active field and the line count is at most the V active field.
- R7: Blank is high when the pixel count lies in the window above the H blank start field and at most the H blank end field, or when the line count lies in the corresponding V blank window.
- R8: Hsync and vsync are active high. Each is high when its count lies above its start field and at most its end field.
- R9: The panel syncs use the same window rule with the panel registers. With panel V fields one smaller than the CRT V sync fields, panel vsync leads CRT vsync by one line.
- R10: While the generator is disabled, both counters are held at zero and all six timing outputs are low.
- R11: The timing registers reach the counters and comparators through shadow copies. The copies load while the generator is disabled, and at the end of the line whose line count equals the shadowed V active field. At any other time a register write has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| pix_x | output | 16 | Current pixel count |
| pix_y | output | 16 | Current line count |
| de | output | 1 | Active video |
| blank | output | 1 | Blank interval |
| hsync | output | 1 | CRT horizontal sync |
| vsync | output | 1 | CRT vertical sync |
| panel_hsync | output | 1 | Flat-panel horizontal sync |
| panel_vsync | output | 1 | Flat-panel vertical sync |

## Verification
The assertions check on every cycle the parts of the behaviour that are local. A locked write must leave the registers unchanged, and writing zero to the key must relock. Each counter must return to zero after its wrap and stay at zero while disabled. A disabled generator must keep all outputs quiet, and the shadow copy must hold between its load points. Only the bench scenarios can show where each window sits in a whole frame: the one-line lead of panel vsync over CRT vsync, and the deferral of a mid-frame write to the next vertical blank.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int DW       = 32;
  localparam int AW       = 4;
  localparam int CW       = 16;
  localparam int NT       = 8;
  localparam int CFG_W    = 5;
  localparam int KEY_ADDR = 0;
  localparam int CFG_ADDR = 1;
  localparam int TIM_BASE = 2;
  localparam logic [DW-1:0] UNLOCK_VAL = 32'h0000_4758;
  // configuration bit positions
  localparam int C_GEN   = 0;
  localparam int C_BLANK = 1;
  localparam int C_HS    = 2;
  localparam int C_VS    = 3;
  localparam int C_PANEL = 4;
  // shadow slot order (matches address minus TIM_BASE)
  localparam int S_HAT = 0;
  localparam int S_HBL = 1;
  localparam int S_HSY = 2;
  localparam int S_VAT = 3;
  localparam int S_VBL = 4;
  localparam int S_VSY = 5;
  localparam int S_PHS = 6;
  localparam int S_PVS = 7;
  localparam int NWIN  = 6;
  typedef logic [NT-1:0][DW-1:0] tim_bank_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic [CFG_W-1:0]     cfg_q,
  output tim_bank_t            tim_q
);
  localparam int IW = $clog2(NT);

  logic [DW-1:0] key_q;
  logic          unlocked;

  assign unlocked = (key_q == UNLOCK_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= '0;
      cfg_q <= '0;
    end else if (wr_en) begin
      if (int'(wr_addr) == KEY_ADDR)
        key_q <= wr_data;
      else if (unlocked && int'(wr_addr) == CFG_ADDR)
        cfg_q <= wr_data[CFG_W-1:0];
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_tim
    always_ff @(posedge clk) begin
      if (!rst_n)
        tim_q[i] <= '0;
      else if (wr_en && unlocked && int'(wr_addr) == TIM_BASE + i)
        tim_q[i] <= wr_data;
    end
  end

  always_comb begin
    int idx;
    idx = int'(rd_addr) - TIM_BASE;
    if (int'(rd_addr) == KEY_ADDR)
      rd_data = key_q;
    else if (int'(rd_addr) == CFG_ADDR)
      rd_data = {{(DW-CFG_W){1'b0}}, cfg_q};
    else if (idx >= 0 && idx < NT)
      rd_data = tim_q[idx[IW-1:0]];
    else
      rd_data = '0;
  end

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) != KEY_ADDR && !unlocked) |=> ($stable(cfg_q) && $stable(tim_q))); // R2
  AST_KEY_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == KEY_ADDR && wr_data == '0) |=> !unlocked); // R2
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = en && step && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !en)
      cnt <= '0;
    else if (step)
      cnt <= wrap ? '0 : cnt + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R10
endmodule

// File: rtl/rtg_window.sv
module rtg_window #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  assign hit = (cnt > lo) && (cnt <= hi);
endmodule

// File: rtl/rtg_raster.sv
module rtg_raster
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic [15:0]   pix_x,
  output logic [15:0]   pix_y,
  output logic          de,
  output logic          blank,
  output logic          hsync,
  output logic          vsync,
  output logic          panel_hsync,
  output logic          panel_vsync
);
  logic [CFG_W-1:0] cfg_q;
  tim_bank_t        tim_q;
  tim_bank_t        sh_q;
  logic             gen;
  logic             h_wrap, v_wrap, load;
  logic [CW-1:0]    h_cnt, v_cnt;
  logic [NWIN-1:0]  hit;
  logic [NWIN-1:0][CW-1:0] w_cnt, w_lo, w_hi;

  rtg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_q(cfg_q), .tim_q(tim_q)
  );

  assign gen  = cfg_q[C_GEN];
  assign load = !gen || (h_wrap && v_cnt == sh_q[S_VAT][CW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)
      sh_q <= '0;
    else if (load)
      sh_q <= tim_q;
  end

  rtg_counter #(.W(CW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .en(gen), .step(1'b1),
    .limit(sh_q[S_HAT][DW-1:CW]), .cnt(h_cnt), .wrap(h_wrap)
  );
  rtg_counter #(.W(CW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .en(gen), .step(h_wrap),
    .limit(sh_q[S_VAT][DW-1:CW]), .cnt(v_cnt), .wrap(v_wrap)
  );

  // window table: 0 hblank, 1 vblank, 2 hsync, 3 vsync, 4 panel hsync, 5 panel vsync
  localparam int WSRC [NWIN] = '{S_HBL, S_VBL, S_HSY, S_VSY, S_PHS, S_PVS};
  localparam logic [NWIN-1:0] WVERT = 6'b101010;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign w_cnt[i] = WVERT[i] ? v_cnt : h_cnt;
    assign w_lo[i]  = sh_q[WSRC[i]][CW-1:0];
    assign w_hi[i]  = sh_q[WSRC[i]][DW-1:CW];
    rtg_window #(.W(CW)) u_win (
      .cnt(w_cnt[i]), .lo(w_lo[i]), .hi(w_hi[i]), .hit(hit[i])
    );
  end

  assign pix_x       = h_cnt;
  assign pix_y       = v_cnt;
  assign de          = gen && (h_cnt <= sh_q[S_HAT][CW-1:0]) && (v_cnt <= sh_q[S_VAT][CW-1:0]);
  assign blank       = gen && cfg_q[C_BLANK] && (hit[0] || hit[1]);
  assign hsync       = gen && cfg_q[C_HS] && hit[2];
  assign vsync       = gen && cfg_q[C_VS] && hit[3];
  assign panel_hsync = gen && cfg_q[C_PANEL] && hit[4];
  assign panel_vsync = gen && cfg_q[C_PANEL] && hit[5];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |-> !(de || blank || hsync || vsync || panel_hsync || panel_vsync)); // R10
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && !load) |=> $stable(sh_q)); // R11
  AST_PANEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[C_PANEL] |-> !(panel_hsync || panel_vsync)); // R4
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    v_wrap |=> (v_cnt == '0 && h_cnt == '0)); // R5
endmodule

// File: tb/rtg_raster_tb_top.sv
module rtg_raster_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h0000_4758;
  localparam int HT = 14;
  localparam int VT = 8;
  localparam int NV = 14;
  // {cycle offset[7:0], de, blank, hsync, vsync, panel_hsync, panel_vsync}
  localparam logic [13:0] VEC [NV] = '{
    {8'd0,   6'b100000}, {8'd7,   6'b100000}, {8'd8,   6'b010000},
    {8'd10,  6'b011010}, {8'd11,  6'b011010}, {8'd12,  6'b010000},
    {8'd13,  6'b010000}, {8'd14,  6'b100000}, {8'd44,  6'b100000},
    {8'd56,  6'b010001}, {8'd73,  6'b010100}, {8'd80,  6'b011110},
    {8'd111, 6'b010000}, {8'd112, 6'b100000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] pix_x, pix_y;
  logic de, blank, hsync, vsync, panel_hsync, panel_vsync;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtg_raster dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_x(pix_x), .pix_y(pix_y),
    .de(de), .blank(blank), .hsync(hsync), .vsync(vsync),
    .panel_hsync(panel_hsync), .panel_vsync(panel_vsync)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) tick();
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [5:0] outs();
    return {de, blank, hsync, vsync, panel_hsync, panel_vsync};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 outputs", outs(), 6'b0);
    check("R1 counters", {pix_x, pix_y}, 32'h0);
    for (int a = 0; a < 16; a++) begin
      bus_read(a[3:0], d);
      check("R1 register", d, 0);
    end
    // R2 locked write ignored
    bus_write(4'd1, 32'h1F);
    bus_read(4'd1, d);
    check("R2 locked cfg", d, 0);
    bus_write(4'd0, KEY);
    bus_read(4'd0, d);
    check("R2 key readback", d, KEY);
    // R3 register map, mode: 8x4 active, 14x8 total
    bus_write(4'd2, {16'd13, 16'd7});
    bus_write(4'd3, {16'd13, 16'd7});
    bus_write(4'd4, {16'd11, 16'd9});
    bus_write(4'd5, {16'd7, 16'd3});
    bus_write(4'd6, {16'd7, 16'd3});
    bus_write(4'd7, {16'd5, 16'd4});
    bus_write(4'd8, {16'd11, 16'd9});
    bus_write(4'd9, {16'd4, 16'd3});
    bus_write(4'd12, 32'hDEAD_BEEF);
    bus_read(4'd4, d);
    check("R3 hsync reg", d, {16'd11, 16'd9});
    bus_read(4'd9, d);
    check("R3 panel vsync reg", d, {16'd4, 16'd3});
    bus_read(4'd12, d);
    check("R3 unmapped", d, 0);
    // R4..R9 frame walk
    bus_write(4'd1, 32'h1F);
    cyc = 0;
    for (int i = 0; i < NV; i++) begin
      int n;
      n = int'(VEC[i][13:6]);
      wait_to(n);
      check("R5 pix_x", pix_x, n % HT);
      check("R5 pix_y", pix_y, (n / HT) % VT);
      check("R6 R7 R8 R9 outputs", outs(), VEC[i][5:0]);
    end
    // R11 mid-frame write deferred to vertical blank
    bus_write(4'd4, {16'd9, 16'd7});
    wait_to(134);
    check("R11 old hsync off", hsync, 0);
    wait_to(136);
    check("R11 old hsync on", hsync, 1);
    wait_to(176);
    check("R11 new hsync on", hsync, 1);
    wait_to(178);
    check("R11 new hsync off", hsync, 0);
    // R2 relock
    bus_write(4'd0, 32'h0);
    bus_write(4'd1, 32'h0);
    bus_read(4'd1, d);
    check("R2 relocked cfg", d, 32'h1F);
    // R10 disable
    bus_write(4'd0, KEY);
    bus_write(4'd1, 32'h0);
    check("R10 outputs", outs(), 6'b0);
    tick();
    check("R10 counters", {pix_x, pix_y}, 32'h0);
    // R4 only generator enabled
    bus_write(4'd1, 32'h1);
    cyc = 0;
    check("R4 de", de, 1);
    wait_to(9);
    check("R4 gated outputs", outs(), 6'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule